// File: doc/BRIEF.md
# Command-Pointer Register Slave for a Byte-Level Serial Bus

This block is the register front end of a light-sensing device that sits on a two-wire serial bus. A bit-level bus engine, not part of this block, turns line activity into byte events: start or repeated start, stop, a received byte with a valid strobe, a request for the next byte to transmit, and the controller's not-acknowledge of a transmitted byte. The block answers each received byte with an acknowledge decision one cycle later and serves each transmit request one cycle later.

A sixteen-location byte map is reached through a pointer that the first byte after the write address loads. The same byte chooses between two framings. In stream framing, data bytes flow until a stop. In counted framing, a length byte comes first: on writes it limits how many bytes are accepted, and on reads the slave sends its own length byte before the data. After each data byte the pointer steps forward and wraps around the map.

On the local side, the sensing core loads two 16-bit channel samples and reads the configuration bytes. A read of a channel's low byte captures the matching high byte, so a two-byte read always returns halves of one sample.

Top module: `lux_regif`

## Requirements
- R1: After reset all configuration outputs are 00h, `ackStrobe` and `txValid` are low, and location Ah reads as the `DEV_ID` parameter (default 50h).
- R2: The first byte after a start is an address byte {7-bit address, read bit in bit 0}. A byte whose upper 7 bits equal `SLV_ADDR` (default 39h) is acknowledged. Any other address is not acknowledged, and every further byte is not acknowledged until the next start.
- R3: The byte after a write address is a command byte and is always acknowledged. Bits [3:0] load the pointer. Bit 4 set selects counted framing and bit 4 clear selects stream framing.
- R4: In stream framing every written data byte is acknowledged and stored at the pointer. The pointer then increments, and it wraps from Fh to 0h.
- R5: In counted framing the byte after the command is a count N. It is acknowledged and not stored in the map. The next N data bytes are written and acknowledged, and later bytes are not acknowledged and change nothing.
- R6: Writes to locations 7h–Fh are acknowledged, advance the pointer and change no location.
- R7: Stream reads return the location at the pointer and then increment it with wrap. Locations 7h, 8h, 9h and Bh read 00h. Location Ah reads `DEV_ID`.
- R8: In counted framing the first byte a read returns is `RD_COUNT` (default 4). The next `RD_COUNT` bytes are data, and any later request returns FFh without moving the pointer.
- R9: Reading Ch (or Eh) captures bits [15:8] of channel 0 (or channel 1). Locations Dh and Fh return the captured byte, even if the core has loaded a new sample since the capture.
- R10: After the controller's not-acknowledge, transmit requests in the same transaction return FFh and leave the pointer where it was. The next read transaction continues at the following location.
- R11: `ackStrobe` pulses exactly in the cycle after each `rxValid`, and `txValid` pulses exactly in the cycle after each `txReq`.
- R12: Locations 0h–6h drive the configuration outputs: 0h control, 1h timing, 2h/3h low threshold (low byte, high byte), 4h/5h high threshold (low byte, high byte), 6h interrupt control. These outputs change only in the cycle after a received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busStart | input | 1 | Start or repeated start strobe |
| busStop | input | 1 | Stop strobe |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| txReq | input | 1 | Request for next byte to transmit |
| mstNack | input | 1 | Controller did not acknowledge last transmitted byte |
| ackStrobe | output | 1 | Acknowledge decision valid |
| ackBit | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| txValid | output | 1 | Transmit byte valid |
| txByte | output | 8 | Byte to transmit |
| coreUpdate | input | 1 | Load new channel samples |
| coreCh0 | input | 16 | Channel 0 sample |
| coreCh1 | input | 16 | Channel 1 sample |
| ctrlOut | output | 8 | Control byte |
| timingOut | output | 8 | Timing/gain byte |
| threshLowOut | output | 16 | Low threshold |
| threshHighOut | output | 16 | High threshold |
| intCtrlOut | output | 8 | Interrupt control byte |

## Verification
The hardest case to reach is the capture of a high byte when the core overwrites the sample between the two halves of a read. The bench issues `coreUpdate` in the middle of an open read transaction, after the low-byte request and before the high-byte request, and checks that the old high byte comes back. Counted writes that overrun their count and reads that run past the slave's own count are driven on purpose. Random stream transfers with random start locations also cross the Fh-to-0h wrap and the Ch/Eh captures in mixed orders.

// File: rtl/lux_regif_pkg.sv
package lux_regif_pkg;
  typedef struct packed {
    logic loadCmd;
    logic loadCnt;
    logic writeReg;
    logic sendData;
    logic sendCount;
    logic sendFill;
  } regif_strb_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_COUNT, PH_WDATA, PH_RDATA, PH_IGNORE
  } regif_phase_t;

  localparam int WR_COUNT = 7;
endpackage

// File: rtl/regif_ctrl.sv
module regif_ctrl
  import lux_regif_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h39,
  parameter int BLK_BIT = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busStart,
  input  logic        busStop,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        txReq,
  input  logic        mstNack,
  input  logic        blkMode,
  input  logic        remZero,
  output regif_strb_t strb,
  output logic        ackStrobe,
  output logic        ackBit,
  output logic        txValid
);
  regif_phase_t phase;
  logic cntPending;
  logic addrMatch;
  logic ackNext;
  logic rxLive;

  assign addrMatch = (rxByte[7:1] == SLV_ADDR);
  assign rxLive    = rxValid && !busStart && !busStop;

  always_comb begin
    strb    = '0;
    ackNext = 1'b0;
    if (rxLive) begin
      case (phase)
        PH_ADDR:  ackNext = addrMatch;
        PH_CMD:   begin ackNext = 1'b1; strb.loadCmd = 1'b1; end
        PH_COUNT: begin ackNext = 1'b1; strb.loadCnt = 1'b1; end
        PH_WDATA: if (!blkMode || !remZero) begin
                    ackNext = 1'b1;
                    strb.writeReg = 1'b1;
                  end
        default:  ackNext = 1'b0;
      endcase
    end else if (txReq) begin
      if (phase != PH_RDATA)        strb.sendFill  = 1'b1;
      else if (cntPending)          strb.sendCount = 1'b1;
      else if (blkMode && remZero)  strb.sendFill  = 1'b1;
      else                          strb.sendData  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      cntPending <= 1'b0;
      ackStrobe  <= 1'b0;
      ackBit     <= 1'b0;
      txValid    <= 1'b0;
    end else begin
      ackStrobe <= rxValid;
      ackBit    <= ackNext;
      txValid   <= txReq;
      if (busStart) begin
        phase      <= PH_ADDR;
        cntPending <= 1'b0;
      end else if (busStop) begin
        phase <= PH_IDLE;
      end else if (rxValid) begin
        case (phase)
          PH_ADDR: begin
            if (!addrMatch)     phase <= PH_IGNORE;
            else if (rxByte[0]) phase <= PH_RDATA;
            else                phase <= PH_CMD;
            cntPending <= addrMatch && rxByte[0] && blkMode;
          end
          PH_CMD:   phase <= rxByte[BLK_BIT] ? PH_COUNT : PH_WDATA;
          PH_COUNT: phase <= PH_WDATA;
          default:  phase <= phase;
        endcase
      end else if (mstNack && phase == PH_RDATA) begin
        phase <= PH_IGNORE;
      end else if (strb.sendCount) begin
        cntPending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regif_dp.sv
module regif_dp
  import lux_regif_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [7:0] DEV_ID = 8'h50,
  parameter logic [7:0] RD_COUNT = 8'd4
) (
  input  logic        clk,
  input  logic        rstN,
  input  regif_strb_t strb,
  input  logic [7:0]  rxByte,
  input  logic        coreUpdate,
  input  logic [15:0] coreCh0,
  input  logic [15:0] coreCh1,
  output logic        blkMode,
  output logic        remZero,
  output logic [7:0]  txByte,
  output logic [7:0]  wrRegs [WR_COUNT]
);
  localparam logic [ADDR_W-1:0] ID_ADR  = ADDR_W'(4'hA);
  localparam logic [ADDR_W-1:0] C0L_ADR = ADDR_W'(4'hC);
  localparam logic [ADDR_W-1:0] C0H_ADR = ADDR_W'(4'hD);
  localparam logic [ADDR_W-1:0] C1L_ADR = ADDR_W'(4'hE);
  localparam logic [ADDR_W-1:0] C1H_ADR = ADDR_W'(4'hF);

  logic [ADDR_W-1:0] ptr;
  logic [7:0]  rem;
  logic [15:0] ch0, ch1;
  logic [7:0]  shad0, shad1;
  logic [7:0]  rdData;

  assign remZero = (rem == 8'd0);

  for (genvar g = 0; g < WR_COUNT; g++) begin : g_wr
    always_ff @(posedge clk) begin
      if (!rstN) wrRegs[g] <= 8'h00;
      else if (strb.writeReg && ptr == ADDR_W'(g)) wrRegs[g] <= rxByte;
    end
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < WR_COUNT; i++)
      if (ptr == ADDR_W'(i)) rdData = wrRegs[i];
    case (ptr)
      ID_ADR:  rdData = DEV_ID;
      C0L_ADR: rdData = ch0[7:0];
      C0H_ADR: rdData = shad0;
      C1L_ADR: rdData = ch1[7:0];
      C1H_ADR: rdData = shad1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0; blkMode <= 1'b0; rem <= 8'd0;
      ch0 <= '0; ch1 <= '0; shad0 <= '0; shad1 <= '0;
      txByte <= 8'h00;
    end else begin
      if (coreUpdate) begin
        ch0 <= coreCh0;
        ch1 <= coreCh1;
      end
      if (strb.loadCmd) begin
        ptr     <= rxByte[ADDR_W-1:0];
        blkMode <= rxByte[ADDR_W];
      end
      if (strb.loadCnt) rem <= rxByte;
      if (strb.writeReg || strb.sendData) begin
        ptr <= ptr + 1'b1;
        if (blkMode) rem <= rem - 8'd1;
      end
      if (strb.sendData) begin
        txByte <= rdData;
        if (ptr == C0L_ADR) shad0 <= ch0[15:8];
        if (ptr == C1L_ADR) shad1 <= ch1[15:8];
      end
      if (strb.sendCount) begin
        txByte <= RD_COUNT;
        rem    <= RD_COUNT;
      end
      if (strb.sendFill) txByte <= 8'hFF;
    end
  end
endmodule

// File: rtl/lux_regif.sv
module lux_regif
  import lux_regif_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h39,
  parameter logic [7:0] DEV_ID   = 8'h50,
  parameter logic [7:0] RD_COUNT = 8'd4,
  parameter int ADDR_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busStart,
  input  logic        busStop,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        txReq,
  input  logic        mstNack,
  output logic        ackStrobe,
  output logic        ackBit,
  output logic        txValid,
  output logic [7:0]  txByte,
  input  logic        coreUpdate,
  input  logic [15:0] coreCh0,
  input  logic [15:0] coreCh1,
  output logic [7:0]  ctrlOut,
  output logic [7:0]  timingOut,
  output logic [15:0] threshLowOut,
  output logic [15:0] threshHighOut,
  output logic [7:0]  intCtrlOut
);
  regif_strb_t strb;
  logic blkMode, remZero;
  logic [7:0] wrRegs [WR_COUNT];

  regif_ctrl #(.SLV_ADDR(SLV_ADDR), .BLK_BIT(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busStart(busStart), .busStop(busStop),
    .rxValid(rxValid), .rxByte(rxByte), .txReq(txReq), .mstNack(mstNack),
    .blkMode(blkMode), .remZero(remZero), .strb(strb),
    .ackStrobe(ackStrobe), .ackBit(ackBit), .txValid(txValid)
  );

  regif_dp #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID), .RD_COUNT(RD_COUNT)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte),
    .coreUpdate(coreUpdate), .coreCh0(coreCh0), .coreCh1(coreCh1),
    .blkMode(blkMode), .remZero(remZero), .txByte(txByte), .wrRegs(wrRegs)
  );

  assign ctrlOut       = wrRegs[0];
  assign timingOut     = wrRegs[1];
  assign threshLowOut  = {wrRegs[3], wrRegs[2]};
  assign threshHighOut = {wrRegs[5], wrRegs[4]};
  assign intCtrlOut    = wrRegs[6];
endmodule

// File: rtl/regif_chk.sv
module regif_chk
  import lux_regif_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        rxValid,
  input logic        txReq,
  input logic        ackStrobe,
  input logic        txValid,
  input logic [7:0]  ctrlOut,
  input logic [15:0] threshLowOut,
  input regif_strb_t strb
);
  assert_ack_follows_rx_R11: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> ackStrobe);
  assert_no_spurious_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> !ackStrobe);
  assert_tx_follows_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    txReq |=> txValid);
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
  assert_cfg_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rxValid) |-> ($stable(ctrlOut) && $stable(threshLowOut)));
endmodule

bind lux_regif regif_chk chk_i (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .txReq(txReq),
  .ackStrobe(ackStrobe), .txValid(txValid), .ctrlOut(ctrlOut),
  .threshLowOut(threshLowOut), .strb(strb)
);

// File: tb/lux_regif_tb_top.sv
module lux_regif_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busStart = 0, busStop = 0, rxValid = 0, txReq = 0, mstNack = 0, coreUpdate = 0;
  logic [7:0] rxByte = 8'h00;
  logic [15:0] coreCh0 = '0, coreCh1 = '0;
  logic ackStrobe, ackBit, txValid;
  logic [7:0] txByte, ctrlOut, timingOut, intCtrlOut;
  logic [15:0] threshLowOut, threshHighOut;

  int compared = 0;
  int mismatched = 0;

  logic [7:0]  mw [7];
  logic [15:0] m0 = '0, m1 = '0;
  logic [7:0]  ms0 = '0, ms1 = '0;

  localparam logic [7:0] WA = 8'h72, RA = 8'h73, ID = 8'h50;

  always #4 clk = ~clk;

  lux_regif dut_i (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mRead(input logic [3:0] p);
    if (p < 7) return mw[p];
    case (p)
      4'hA: return ID;
      4'hC: begin ms0 = m0[15:8]; return m0[7:0]; end
      4'hD: return ms0;
      4'hE: begin ms1 = m1[15:8]; return m1[7:0]; end
      4'hF: return ms1;
      default: return 8'h00;
    endcase
  endfunction

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic putByte(input logic [7:0] b, output logic a);
    @(negedge clk) begin rxValid = 1'b1; rxByte = b; end
    @(negedge clk) rxValid = 1'b0;
    a = ackStrobe && ackBit;
  endtask

  task automatic getByte(output logic [7:0] b);
    @(negedge clk) txReq = 1'b1;
    @(negedge clk) txReq = 1'b0;
    b = txValid ? txByte : 8'hxx;
  endtask

  task automatic coreLoad(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk) begin coreCh0 = a; coreCh1 = b; coreUpdate = 1'b1; end
    @(negedge clk) coreUpdate = 1'b0;
    m0 = a; m1 = b;
  endtask

  task automatic openCmd(input logic [7:0] cmd);
    logic a;
    pulse(busStart);
    putByte(WA, a); chk("R2 address ack", a, 1);
    putByte(cmd, a); chk("R3 command ack", a, 1);
  endtask

  task automatic openRead();
    logic a;
    pulse(busStart);
    putByte(RA, a); chk("R2 read address ack", a, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    logic a;
    logic [7:0] b;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 7; i++) mw[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrlOut, 0);
    chk("R1 thresh", threshHighOut, 0);
    chk("R1 ack idle", ackStrobe, 0);
    chk("R1 tx idle", txValid, 0);
    openCmd(8'h0A); openRead(); getByte(b); chk("R1 R7 id", b, ID);
    pulse(mstNack); pulse(busStop);

    // R2 wrong address, then bytes ignored
    pulse(busStart);
    putByte(8'h20, a); chk("R2 foreign address nack", a, 0);
    putByte(8'h00, a); chk("R2 later byte nack", a, 0);
    putByte(8'h5C, a); chk("R2 later byte nack", a, 0);
    pulse(busStop);
    chk("R2 nothing written", ctrlOut, 0);

    // R4 R12 stream write of 0h-6h
    openCmd(8'h00);
    for (int i = 0; i < 7; i++) begin
      putByte(8'h11 * (i + 1), a); chk("R4 stream data ack", a, 1);
      mw[i] = 8'h11 * (i + 1);
    end
    pulse(busStop);
    chk("R12 ctrl", ctrlOut, 8'h11);
    chk("R12 timing", timingOut, 8'h22);
    chk("R12 low threshold", threshLowOut, 16'h4433);
    chk("R12 high threshold", threshHighOut, 16'h6655);
    chk("R12 int ctrl", intCtrlOut, 8'h77);

    // R4 R6 wrap from Fh and ignored writes
    openCmd(8'h0F);
    putByte(8'hAA, a); chk("R6 write to Fh acked", a, 1);
    putByte(8'hBB, a); chk("R4 wrap data ack", a, 1);
    pulse(busStop); mw[0] = 8'hBB;
    chk("R4 wrap to 0h", ctrlOut, 8'hBB);
    openCmd(8'h07);
    putByte(8'hCC, a); chk("R6 write to 7h acked", a, 1);
    putByte(8'hCD, a); putByte(8'hCE, a); putByte(8'hCF, a);
    putByte(8'hD0, a); chk("R6 write to Bh acked", a, 1);
    pulse(busStop);
    openCmd(8'h07); openRead();
    getByte(b); chk("R6 R7 7h reads 0", b, 0);
    getByte(b); chk("R6 R7 8h reads 0", b, 0);
    getByte(b); chk("R6 R7 9h reads 0", b, 0);
    getByte(b); chk("R6 Ah keeps id", b, ID);
    getByte(b); chk("R6 R7 Bh reads 0", b, 0);
    pulse(mstNack); pulse(busStop);

    // R5 counted write with overrun
    openCmd(8'h11);
    putByte(8'h02, a); chk("R5 count ack", a, 1);
    putByte(8'h9A, a); chk("R5 data 1 ack", a, 1);
    putByte(8'h9B, a); chk("R5 data 2 ack", a, 1);
    putByte(8'h9C, a); chk("R5 overrun nack", a, 0);
    putByte(8'h9D, a); chk("R5 overrun nack", a, 0);
    pulse(busStop); mw[1] = 8'h9A; mw[2] = 8'h9B;
    chk("R5 count not stored", ctrlOut, 8'hBB);
    chk("R5 timing", timingOut, 8'h9A);
    chk("R5 overrun dropped", threshLowOut, 16'h449B);
    openCmd(8'h13);
    putByte(8'h00, a); chk("R5 zero count ack", a, 1);
    putByte(8'h01, a); chk("R5 zero count data nack", a, 0);
    pulse(busStop);
    chk("R5 zero count no write", threshLowOut, 16'h449B);

    // R8 counted read
    openCmd(8'h10); openRead();
    getByte(b); chk("R8 count byte", b, 8'd4);
    getByte(b); chk("R8 data 0h", b, 8'hBB);
    getByte(b); chk("R8 data 1h", b, 8'h9A);
    getByte(b); chk("R8 data 2h", b, 8'h9B);
    getByte(b); chk("R8 data 3h", b, 8'h44);
    getByte(b); chk("R8 past count", b, 8'hFF);
    getByte(b); chk("R8 past count", b, 8'hFF);
    pulse(mstNack); pulse(busStop);

    // R9 coherent sample across a core update
    coreLoad(16'h1234, 16'hABCD);
    openCmd(8'h0C); openRead();
    getByte(b); chk("R9 ch0 low", b, 8'h34);
    coreLoad(16'h5678, 16'hEF01);
    getByte(b); chk("R9 ch0 high latched", b, 8'h12);
    getByte(b); chk("R9 ch1 low", b, 8'h01);
    getByte(b); chk("R9 ch1 high latched", b, 8'hEF);
    pulse(mstNack); pulse(busStop);
    ms0 = 8'h12; ms1 = 8'hEF;

    // R10 controller not-acknowledge
    openCmd(8'h06); openRead();
    getByte(b); chk("R10 last byte", b, 8'h77);
    pulse(mstNack);
    getByte(b); chk("R10 after nack fill", b, 8'hFF);
    getByte(b); chk("R10 after nack fill", b, 8'hFF);
    pulse(busStop);
    openRead();
    getByte(b); chk("R10 resumes at 7h", b, 8'h00);
    getByte(b); getByte(b);
    getByte(b); chk("R10 R7 continues to Ah", b, ID);
    pulse(mstNack); pulse(busStop);

    // Random stream traffic against the model (R4 R7 R9)
    for (int it = 0; it < 40; it++) begin
      logic [3:0] st;
      int n;
      st = 4'($urandom);
      n = 1 + int'($urandom % 6);
      if ($urandom % 3 == 0) coreLoad(16'($urandom), 16'($urandom));
      openCmd({4'h0, st});
      for (int k = 0; k < n; k++) begin
        logic [7:0] d;
        logic [3:0] p;
        d = 8'($urandom);
        p = st + 4'(k);
        putByte(d, a); chk("R4 random write ack", a, 1);
        if (p < 7) mw[p] = d;
      end
      pulse(busStop);
      openCmd({4'h0, st}); openRead();
      for (int k = 0; k < n + 2; k++) begin
        logic [3:0] p;
        logic [7:0] e;
        p = st + 4'(k);
        e = mRead(p);
        getByte(b); chk("R7 R9 random read", b, e);
      end
      pulse(mstNack); pulse(busStop);
    end
    chk("R12 final ctrl", ctrlOut, mw[0]);
    chk("R12 final high threshold", threshHighOut, {mw[5], mw[4]});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule